// File: doc/BRIEF.md
# TV Flicker Reduction Pixel Filter

This block smooths a stream of 24-bit pixels before they go to an interlaced television, where single-line detail and sharp one-pixel edges flicker. It holds one 8-bit control byte, written through an index/data port. When that byte enables them, it applies two filters: a three-tap weighted average along the scanline, and an average of each pixel with the same column of the previous scanline. Either filter can run alone, or both can run. When both run, the horizontal stage comes first.

Pixels enter with a valid strobe and start-of-frame, start-of-line and end-of-line markers. Within a line, pixels arrive on consecutive cycles; gaps are allowed only between lines. Each pixel and its markers leave the block exactly three clock cycles after they enter, whatever the enables are. Filters can therefore be switched between lines without disturbing the markers. A line store of `LINE_MAX` pixels keeps the horizontally processed previous line for the vertical average.

Top module: `tvflick_filter`

## Requirements
- R1: While reset is asserted and after it is released, `ctrl_rd` is 0 and `out_valid` is 0 until a pixel has passed through.
- R2: A write with `reg_we` = 1 and `reg_idx` = 0x77 stores `reg_wdata` in all 8 control bits, visible on `ctrl_rd` the next cycle. A write to any other index leaves the control byte unchanged.
- R3: Control bit 0 is the master enable, bit 1 the clock-doubling enable, bit 2 the vertical enable and bit 3 the horizontal enable. The horizontal filter acts only when bits 3, 1 and 0 are all 1. Otherwise that stage passes pixels unchanged.
- R4: With the horizontal filter in effect, each 8-bit channel (bits 23:16, 15:8 and 7:0) of the output is (centre>>1) + (left>>2) + (right>>2), using truncating shifts.
- R5: For the first pixel of a line the left neighbour is the pixel itself, and for the last pixel the right neighbour is the pixel itself.
- R6: The vertical filter acts only when bits 2, 1 and 0 are all 1. Each channel is then (current>>1) + (previous-line>>1), where previous-line is the pixel in the same column of the preceding line.
- R7: The vertical stage passes pixels unchanged on the first line of a frame (the line that starts with `in_sof`) and at columns at or beyond `LINE_MAX`.
- R8: When both filters are in effect, the vertical stage averages horizontally filtered pixels. The line store always holds the horizontal stage's output for the previous line, whether or not the vertical filter is enabled.
- R9: Every input pixel appears on the output exactly 3 cycles later, with its start-of-frame, start-of-line and end-of-line markers. This holds for any setting of the enables, including a change between lines.
- R10: Control bits 7:4 are stored and read back but have no effect on the pixel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index; 0x77 selects the control byte |
| reg_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Current control byte |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | 24 | Input pixel, three 8-bit channels |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | First pixel of a frame |
| out_sol | output | 1 | First pixel of a line |
| out_eol | output | 1 | Last pixel of a line |
| out_pix | output | 24 | Filtered pixel |

## Verification
The assertions check the following on every cycle:
- the three-cycle alignment of valid and the line and frame markers;
- the loading of the control byte at index 0x77, and that it holds otherwise;
- the unchanged passage of a pixel whenever neither filter was in effect at its stage.

The bench's scenarios show the rest, because checking it needs the neighbouring pixels and the previous line as context:
- the weighted values and the truncation at full scale;
- edge replication at both ends of a line;
- the first-line and beyond-`LINE_MAX` passthrough;
- the horizontal-then-vertical ordering;
- enabling a filter between lines;
- that bits 7:4 do not matter.

// File: rtl/tvflick_filter.sv
module tvflick_filter #(
  parameter int CH_W = 8,
  parameter int NCH = 3,
  parameter int LINE_MAX = 256,
  parameter logic [7:0] CFG_INDEX = 8'h77
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [7:0]          reg_idx,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          ctrl_rd,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_sol,
  input  logic                in_eol,
  input  logic [CH_W*NCH-1:0] in_pix,
  output logic                out_valid,
  output logic                out_sof,
  output logic                out_sol,
  output logic                out_eol,
  output logic [CH_W*NCH-1:0] out_pix
);
  localparam int PW = CH_W * NCH;
  localparam int AW = $clog2(LINE_MAX);
  localparam int CW = $clog2(LINE_MAX + 1);

  logic [7:0] cfg_q;
  wire cfg_hit = reg_we && (reg_idx == CFG_INDEX);
  wire h_on = cfg_q[3] & cfg_q[1] & cfg_q[0];
  wire v_on = cfg_q[2] & cfg_q[1] & cfg_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else if (cfg_hit) cfg_q <= reg_wdata;
  assign ctrl_rd = cfg_q;

  // horizontal stage: s1 is the centre, s2 the left pixel, input the right one
  logic          s1_v, s1_sof, s1_sol, s1_eol;
  logic [PW-1:0] s1_pix, s2_pix;
  logic          h_v, h_sof, h_sol, h_eol;
  logic [PW-1:0] h_pix;
  logic [PW-1:0] h_filt, left_px, right_px;

  assign left_px  = s1_sol ? s1_pix : s2_pix;
  assign right_px = s1_eol ? s1_pix : in_pix;

  // vertical stage
  logic [CW-1:0] col_q, col_idx;
  logic [AW-1:0] addr;
  logic          prev_ok_q, in_buf, use_v;
  logic [PW-1:0] prv_pix, v_filt;
  logic [PW-1:0] line_mem [LINE_MAX];

  assign col_idx = h_sol ? '0 : col_q;
  assign in_buf  = col_idx < CW'(LINE_MAX);
  assign addr    = col_idx[AW-1:0];
  assign prv_pix = line_mem[addr];
  assign use_v   = v_on && !h_sof && prev_ok_q && in_buf;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [CH_W-1:0] lc = left_px[c*CH_W +: CH_W];
    wire [CH_W-1:0] cc = s1_pix[c*CH_W +: CH_W];
    wire [CH_W-1:0] rc = right_px[c*CH_W +: CH_W];
    wire [CH_W-1:0] hc = h_pix[c*CH_W +: CH_W];
    wire [CH_W-1:0] pc = prv_pix[c*CH_W +: CH_W];
    assign h_filt[c*CH_W +: CH_W] = (cc >> 1) + (lc >> 2) + (rc >> 2);
    assign v_filt[c*CH_W +: CH_W] = (hc >> 1) + (pc >> 1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {s1_v, s1_sof, s1_sol, s1_eol} <= '0;
      s1_pix <= '0;
      s2_pix <= '0;
      {h_v, h_sof, h_sol, h_eol} <= '0;
      h_pix <= '0;
    end else begin
      {s1_v, s1_sof, s1_sol, s1_eol} <= {in_valid, in_sof, in_sol, in_eol};
      s1_pix <= in_pix;
      s2_pix <= s1_pix;
      {h_v, h_sof, h_sol, h_eol} <= {s1_v, s1_sof, s1_sol, s1_eol};
      h_pix <= h_on ? h_filt : s1_pix;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      col_q <= '0;
      prev_ok_q <= 1'b0;
      {out_valid, out_sof, out_sol, out_eol} <= '0;
      out_pix <= '0;
    end else begin
      {out_valid, out_sof, out_sol, out_eol} <= {h_v, h_sof, h_sol, h_eol};
      out_pix <= use_v ? v_filt : h_pix;
      if (h_v) begin
        col_q <= in_buf ? CW'(col_idx + 1'b1) : col_idx;
        if (h_eol) prev_ok_q <= 1'b1;
        else if (h_sof) prev_ok_q <= 1'b0;
      end
    end

  always_ff @(posedge clk)
    if (h_v && in_buf) line_mem[addr] <= h_pix;

  // checks
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> ctrl_rd == $past(reg_wdata));
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable(ctrl_rd));
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> out_valid == $past(in_valid, 3));
  assert_markers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(in_valid, 3)) |->
      {out_sof, out_sol, out_eol} == $past({in_sof, in_sol, in_eol}, 3));
  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(in_valid, 3) && !$past(h_on, 2) && !$past(v_on, 1))
      |-> out_pix == $past(in_pix, 3));
endmodule

// File: tb/tvflick_filter_tb_top.sv
module tvflick_filter_tb_top;
  localparam int W = 6;
  localparam int LM = 4;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_idx = '0, reg_wdata = '0, ctrl_rd;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [23:0] in_pix = '0;
  logic out_valid, out_sof, out_sol, out_eol;
  logic [23:0] out_pix;

  always #2.5 clk = ~clk;

  tvflick_filter #(.LINE_MAX(LM)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .in_valid(in_valid),
    .in_sof(in_sof), .in_sol(in_sol), .in_eol(in_eol), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_eol(out_eol), .out_pix(out_pix));

  // {cfg line0, cfg line1, pixel seed}
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 8'h00, 24'h13579B},  // R3 all off
    {8'h0B, 8'h0B, 24'h2468AC},  // R4 R5 horizontal only
    {8'h09, 8'h09, 24'h8D1E2F},  // R3 no doubling
    {8'h07, 8'h07, 24'h4C3B2A},  // R6 R7 vertical only
    {8'h0F, 8'h0F, 24'hA1B2C3},  // R8 both
    {8'h7B, 8'hF7, 24'h5E6F70},  // R10 upper bits
    {8'h05, 8'h07, 24'h0F1E2D},  // R9 vertical enabled between lines
    {8'h0F, 8'h0F, 24'hFFFFFF}   // R4 R6 full scale
  };
  localparam string TAG [NV] = '{"R3", "R4_R5", "R3", "R6_R7", "R8", "R10", "R9", "R4_R6"};

  int n_chk = 0, n_bad = 0, cyc = 0, cap_n = 0;
  logic [26:0] cap [512];
  int cap_cyc [512];
  logic [26:0] expv [2*W];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && out_valid) begin
      cap[cap_n] = {out_sof, out_sol, out_eol, out_pix};
      cap_cyc[cap_n] = cyc;
      cap_n++;
    end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk)
    if (cyc == 50000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      summary();
    end

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    in_valid = 0; reg_we = 1; reg_idx = idx; reg_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; reg_we = 0; in_sof = 0; in_sol = 0; in_eol = 0;
  endtask

  task automatic px(input logic [23:0] p, input bit sof, input bit sol, input bit eol);
    @(negedge clk);
    reg_we = 0; in_valid = 1; in_pix = p; in_sof = sof; in_sol = sol; in_eol = eol;
  endtask

  function automatic logic [23:0] pix_at(input logic [23:0] sd, input int ln, input int col);
    logic [23:0] t;
    if (sd == 24'hFFFFFF) return sd;
    t = 24'(sd + 24'h1F3A5B * 24'(ln * 8 + col + 1));
    return t ^ {t[11:0], t[23:12]};
  endfunction

  function automatic logic [23:0] wavg(input logic [23:0] l, input logic [23:0] c, input logic [23:0] r);
    logic [23:0] o;
    for (int k = 0; k < 3; k++)
      o[8*k +: 8] = (c[8*k +: 8] >> 1) + (l[8*k +: 8] >> 2) + (r[8*k +: 8] >> 2);
    return o;
  endfunction

  function automatic logic [23:0] vavg(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] o;
    for (int k = 0; k < 3; k++) o[8*k +: 8] = (a[8*k +: 8] >> 1) + (b[8*k +: 8] >> 1);
    return o;
  endfunction

  task automatic build(input logic [7:0] c0, input logic [7:0] c1, input logic [23:0] sd);
    logic [23:0] raw [2][W];
    logic [23:0] hp [2][W];
    logic [7:0] cf;
    for (int ln = 0; ln < 2; ln++)
      for (int c = 0; c < W; c++) raw[ln][c] = pix_at(sd, ln, c);
    for (int ln = 0; ln < 2; ln++) begin
      cf = ln == 0 ? c0 : c1;
      for (int c = 0; c < W; c++) begin
        if (cf[3] && cf[1] && cf[0])
          hp[ln][c] = wavg(raw[ln][c == 0 ? 0 : c - 1], raw[ln][c], raw[ln][c == W - 1 ? c : c + 1]);
        else hp[ln][c] = raw[ln][c];
        if (ln == 1 && cf[2] && cf[1] && cf[0] && c < LM)
          expv[ln*W + c] = {1'b0, c == 0, c == W - 1, vavg(hp[1][c], hp[0][c])};
        else
          expv[ln*W + c] = {ln == 0 && c == 0, c == 0, c == W - 1, hp[ln][c]};
      end
    end
  endtask

  initial begin
    logic [7:0] c0, c1;
    logic [23:0] sd;
    int base, t0;
    in_valid = 1; in_sol = 1;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", 32'(out_valid), 0);
    check("R1 reset ctrl", 32'(ctrl_rd), 0);
    in_valid = 0; in_sol = 0;
    rst_n = 1;
    idle();
    check("R1 after release out_valid", 32'(out_valid), 0);

    wr(8'h76, 8'hFF); idle();
    check("R2 other index ignored", 32'(ctrl_rd), 0);
    wr(8'h77, 8'hA5); idle();
    check("R2 R10 write readback", 32'(ctrl_rd), 32'hA5);
    wr(8'h37, 8'h0F); idle();
    check("R2 other index keeps value", 32'(ctrl_rd), 32'hA5);

    for (int v = 0; v < NV; v++) begin
      c0 = VEC[v][39:32]; c1 = VEC[v][31:24]; sd = VEC[v][23:0];
      build(c0, c1, sd);
      base = cap_n;
      wr(8'h77, c0); idle();
      for (int c = 0; c < W; c++) begin
        px(pix_at(sd, 0, c), c == 0, c == 0, c == W - 1);
        if (c == 0) t0 = cyc;
      end
      repeat (3) idle();
      wr(8'h77, c1); idle();
      for (int c = 0; c < W; c++) px(pix_at(sd, 1, c), 0, c == 0, c == W - 1);
      repeat (6) idle();
      check({TAG[v], " R9 output count"}, 32'(cap_n - base), 2 * W);
      check({TAG[v], " R9 latency"}, 32'(cap_cyc[base] - t0), 3);
      for (int i = 0; i < 2 * W; i++)
        check($sformatf("%s pixel %0d", TAG[v], i), 32'(cap[base + i]), 32'(expv[i]));
      if (v == NV - 1)
        check("R4 R6 full-scale truncation", 32'(cap[base + W + 1][23:0]), 32'hFCFCFC);
    end
    summary();
  end
endmodule